// File: doc/BRIEF.md
# Universal Shift Register with Shared Bus Port

This block is a parameterised register (eight bits by default) that, on each rising clock edge, keeps its contents, moves them one place toward the high index, moves them one place toward the low index, or captures a word from a shared parallel bus. One bidirectional bus both loads the register and reads it back. It is split into three signals: `port_in` carries bus data into the block, `port_out` always carries the register value, and `port_oe` drives the enable of an external tri-state buffer.

The bus is released when either of two disable inputs is high. It is also released whenever the load mode is selected, so that an outside agent can drive the word that is to be captured. Two serial outputs carry the lowest and highest bits and are never released. Wiring the high-end output of one instance into the low-end serial input of a second instance builds a wider chain. An active-low asynchronous reset clears the register.

The data here is a bit-level shift path with no transaction boundary, so the block has no valid/ready handshake. Every pin is a plain control or data signal.

Top module: `usr_bus_shifter`

## Requirements
- R1: With `mode_sel` = 2'b00 at a rising edge, the register keeps its value.
- R2: With `mode_sel` = 2'b01 at a rising edge, bit 0 takes `ser_lo_in` and each bit i>0 takes the old bit i-1. The old top bit is lost.
- R3: With `mode_sel` = 2'b10 at a rising edge, the top bit takes `ser_hi_in` and each bit i<W-1 takes the old bit i+1.
- R4: With `mode_sel` = 2'b11 at a rising edge, the register takes `port_in`.
- R5: While `mode_sel` = 2'b11, `port_oe` is low.
- R6: `port_oe` is low while `dis_a` or `dis_b` is high. Otherwise it is high in modes 00, 01 and 10. `port_out` always shows the register.
- R7: The disable inputs have no effect on holding, shifting, loading or clearing.
- R8: A low `rst_n` clears the register at once, without waiting for a clock edge. It holds the register at zero against the clock and every mode while it stays low.
- R9: `end_lo_out` equals register bit 0 and `end_hi_out` equals bit W-1 at all times, whatever the state of `port_oe`.
- R10: Two instances, with the first one's `end_hi_out` feeding the second one's `ser_lo_in` and both in mode 01, shift as one register of width 2W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | 00 keep, 01 shift up, 10 shift down, 11 load |
| dis_a | input | 1 | Bus release request, active high |
| dis_b | input | 1 | Second bus release request, active high |
| ser_lo_in | input | 1 | Serial bit entering at bit 0 when shifting up |
| ser_hi_in | input | 1 | Serial bit entering at bit W-1 when shifting down |
| port_in | input | W | Word sampled from the shared bus |
| port_out | output | W | Register contents toward the bus buffer |
| port_oe | output | 1 | Bus buffer enable |
| end_lo_out | output | 1 | Register bit 0 |
| end_hi_out | output | 1 | Register bit W-1 |

## Verification
The clocked properties assume that `mode_sel`, the serial inputs and `port_in` hold stable values at each rising edge. They also assume that reset is released away from an edge. The bench changes every input only on the falling clock edge, and it asserts or releases reset only between edges. Each mode is exercised with the bus both enabled and released. This shows that the disable pins change only `port_oe` and never the stored value.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_KEEP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_next_calc.sv
module usr_next_calc
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  usr_mode_e    mode,
  input  logic         ser_lo,
  input  logic         ser_hi,
  input  logic [W-1:0] par,
  output logic [W-1:0] nxt
);
  logic [W-1:0] up_src;
  logic [W-1:0] dn_src;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lo_end
      assign up_src[i] = ser_lo;
    end else begin : g_lo_mid
      assign up_src[i] = cur[i-1];
    end
    if (i == W-1) begin : g_hi_end
      assign dn_src[i] = ser_hi;
    end else begin : g_hi_mid
      assign dn_src[i] = cur[i+1];
    end
    always_comb begin
      unique case (mode)
        MODE_UP:   nxt[i] = up_src[i];
        MODE_DOWN: nxt[i] = dn_src[i];
        MODE_LOAD: nxt[i] = par[i];
        default:   nxt[i] = cur[i];
      endcase
    end
  end
endmodule

// File: rtl/usr_port_gate.sv
module usr_port_gate
  import usr_pkg::*;
(
  input  usr_mode_e mode,
  input  logic      dis_a,
  input  logic      dis_b,
  output logic      oe
);
  logic released;
  assign released = dis_a | dis_b | (mode == MODE_LOAD);
  assign oe = ~released;
endmodule

// File: rtl/usr_bus_shifter.sv
module usr_bus_shifter
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_sel,
  input  logic         dis_a,
  input  logic         dis_b,
  input  logic         ser_lo_in,
  input  logic         ser_hi_in,
  input  logic [W-1:0] port_in,
  output logic [W-1:0] port_out,
  output logic         port_oe,
  output logic         end_lo_out,
  output logic         end_hi_out
);
  localparam int TOP = W - 1;

  usr_mode_e    mode;
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  assign mode = usr_mode_e'(mode_sel);

  usr_next_calc #(.W(W)) u_next (
    .cur    (state_q),
    .mode   (mode),
    .ser_lo (ser_lo_in),
    .ser_hi (ser_hi_in),
    .par    (port_in),
    .nxt    (state_d)
  );

  usr_port_gate u_gate (
    .mode  (mode),
    .dis_a (dis_a),
    .dis_b (dis_b),
    .oe    (port_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign port_out   = state_q;
  assign end_lo_out = state_q[0];
  assign end_hi_out = state_q[TOP];

  // R1
  a_r1_keep: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b00 |=> $stable(port_out));
  // R2
  a_r2_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b01 |=> port_out == {$past(port_out[TOP-1:0]), $past(ser_lo_in)});
  // R3
  a_r3_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b10 |=> port_out == {$past(ser_hi_in), $past(port_out[TOP:1])});
  // R4
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b11 |=> port_out == $past(port_in));
  // R5
  a_r5_load_releases: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b11 |-> !port_oe);
  // R6
  a_r6_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_a || dis_b) |-> !port_oe);
  // R8
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r8_reset_clear: assert (port_out == '0);
    end
  end
endmodule

// File: tb/tb_usr_bus_shifter.sv
module tb_usr_bus_shifter;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode_sel = 2'b00;
  logic         dis_a = 1'b0, dis_b = 1'b0;
  logic         ser_lo_in = 1'b0, ser_hi_in = 1'b0;
  logic [W-1:0] port_in = '0, pin_b = '0;
  logic [W-1:0] port_out, out_b;
  logic         port_oe, oe_b, end_lo_out, end_hi_out, lo_b, hi_b;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model;

  always #5 clk = ~clk;

  usr_bus_shifter #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .dis_a(dis_a), .dis_b(dis_b),
    .ser_lo_in(ser_lo_in), .ser_hi_in(ser_hi_in), .port_in(port_in),
    .port_out(port_out), .port_oe(port_oe), .end_lo_out(end_lo_out), .end_hi_out(end_hi_out)
  );

  usr_bus_shifter #(.W(W)) dut_b (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .dis_a(1'b0), .dis_b(1'b0),
    .ser_lo_in(end_hi_out), .ser_hi_in(1'b0), .port_in(pin_b),
    .port_out(out_b), .port_oe(oe_b), .end_lo_out(lo_b), .end_hi_out(hi_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive, check enables, clock once, compare at next falling edge.
  task automatic step(input logic [1:0] m, input logic lo, input logic hi,
                      input logic [W-1:0] pin, input logic da, input logic db, input string req);
    mode_sel = m; ser_lo_in = lo; ser_hi_in = hi; port_in = pin; dis_a = da; dis_b = db;
    #1;
    check("R5/R6 oe", {31'b0, port_oe}, {31'b0, !(da || db || m == 2'b11)});
    case (m)
      2'b01: model = {model[W-2:0], lo};
      2'b10: model = {hi, model[W-1:1]};
      2'b11: model = pin;
      default: model = model;
    endcase
    @(negedge clk);
    check(req, {24'b0, port_out}, {24'b0, model});
    check("R9 ends", {30'b0, end_hi_out, end_lo_out}, {30'b0, model[W-1], model[0]});
  endtask

  task automatic t_reset_state();
    check("R8 reset state", {24'b0, port_out}, 32'h0);
    @(negedge clk); rst_n = 1'b1; model = '0;
  endtask

  task automatic t_load_keep(input logic da, input logic db);
    step(2'b11, 0, 0, 8'hA5, da, db, "R4 load");
    step(2'b00, 1, 1, 8'h3C, da, db, "R1 keep");
    step(2'b00, 0, 1, 8'hFF, da, db, "R1 keep");
  endtask

  task automatic t_shift_up(input logic da, input logic db);
    step(2'b11, 0, 0, 8'h81, da, db, "R4 load");
    for (int i = 0; i < 10; i++) step(2'b01, i[0] ^ i[2], 0, 8'h00, da, db, "R2 shift up");
  endtask

  task automatic t_shift_down(input logic da, input logic db);
    step(2'b11, 0, 0, 8'h5A, da, db, "R4 load");
    for (int i = 0; i < 10; i++) step(2'b10, 0, i[1], 8'hFF, da, db, "R3 shift down");
  endtask

  task automatic t_disable_transparent();
    // R7: identical sequence with bus released must give identical contents
    logic [W-1:0] ref_en;
    step(2'b11, 0, 0, 8'hC3, 0, 0, "R7 load en");
    step(2'b01, 1, 0, 8'h00, 0, 0, "R7 up en");
    step(2'b10, 0, 1, 8'h00, 0, 0, "R7 down en");
    ref_en = port_out;
    step(2'b11, 0, 0, 8'hC3, 1, 1, "R7 load dis");
    step(2'b01, 1, 0, 8'h00, 0, 1, "R7 up dis");
    step(2'b10, 0, 1, 8'h00, 1, 0, "R7 down dis");
    check("R7 same contents", {24'b0, port_out}, {24'b0, ref_en});
  endtask

  task automatic t_mid_reset();
    step(2'b11, 0, 0, 8'hEE, 0, 0, "R4 load");
    mode_sel = 2'b11; port_in = 8'h77;
    #2 rst_n = 1'b0;
    #1 check("R8 async clear", {24'b0, port_out}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R8 overrides load", {24'b0, port_out}, 32'h0);
    check("R9 ends in reset", {30'b0, end_hi_out, end_lo_out}, 32'h0);
    rst_n = 1'b1; model = '0;
    step(2'b00, 1, 1, 8'h00, 0, 0, "R1 keep after reset");
  endtask

  task automatic t_cascade();
    logic [2*W-1:0] wide;
    pin_b = 8'h96;
    step(2'b11, 0, 0, 8'h3D, 0, 0, "R10 load low");
    check("R10 load high", {24'b0, out_b}, 32'h96);
    wide = {8'h96, 8'h3D};
    for (int i = 0; i < 12; i++) begin
      step(2'b01, i[0], 0, 8'h00, 0, 0, "R10 low half");
      wide = {wide[2*W-2:0], i[0]};
      check("R10 chain", {16'b0, out_b, port_out}, {16'b0, wide});
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model = '0;
    @(negedge clk);
    t_reset_state();
    t_load_keep(0, 0);
    t_load_keep(1, 0);
    t_shift_up(0, 0);
    t_shift_up(0, 1);
    t_shift_down(0, 0);
    t_shift_down(1, 1);
    t_disable_transparent();
    t_mid_reset();
    t_cascade();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule